// File: doc/BRIEF.md
# Memory-Mapped Calendar Clock with Alarm and Periodic Interrupt

This block keeps wall-clock time and a calendar for a processor. A one-second strobe on `tick_i` moves seconds, minutes, hours, weekday, day of month, month and a two-digit year forward, carrying between fields with the right month length and an extra day for February in leap years. The processor sets and reads every field through a small synchronous register bus, as if it were memory. After a write, the fields keep advancing on their own.

Two event sources share one interrupt line. The alarm compares the time of day with three preset registers. The periodic source fires once every 1, 60 or 3600 ticks. Each source sets a sticky status bit, and software clears it by writing a one. The addresses above the clock registers are plain byte storage for software.

The periodic source is a two-state machine. In `PER_IDLE` it counts nothing. In `PER_RUN` it counts ticks up to the selected period. A write to the control register performs the `restart` transition: the state becomes `PER_RUN` when the new code is non-zero, `PER_IDLE` when it is zero, and the counter is cleared. While in `PER_RUN`, a tick that reaches the last count performs the `wrap` transition, which fires the event and sets the counter back to zero.

Top module: `rtc_regblock`

## Requirements
- R1: After reset, the clock reads 00:00:00, weekday 1, day 1, month 1, year 0. Alarm registers, control, status, `bus_rdata_o` and `irq_o` are all zero.
- R2: The registers sit at these addresses: seconds 0, minutes 1, hours 2, weekday 3, day 4, month 5, year 6, alarm seconds 7, alarm minutes 8, alarm hours 9, control 10, status 11. A write keeps only the field width: 6 bits for seconds and minutes, 5 for hours and day, 3 for weekday, 4 for month, 7 for year. A read returns the field zero-extended on `bus_rdata_o` one clock after the read strobe.
- R3: On a tick, seconds advance and wrap from 59 to 0. The carry advances minutes, which wrap from 59 to 0, and hours, which wrap from 23 to 0.
- R4: When hours wrap, the weekday advances 1..7 and returns from 7 to 1.
- R5: When hours wrap on the last day of the month, the day returns to 1 and the month advances. Months 4, 6, 9 and 11 have 30 days, February has 28 days in other years, and every other month has 31. December wraps to month 1 and advances the year, and year 99 wraps to 0.
- R6: A year whose value is a multiple of 4, including 0, is a leap year, and February then has 29 days.
- R7: A bus write to any of addresses 0..6 in the same cycle as a tick stores the written value. No time or date field advances in that cycle.
- R8: Control bit 2 enables the alarm. When it is set and a tick moves the time to a value whose hours, minutes and seconds all equal the alarm registers, status bit 0 is set at that same clock edge.
- R9: Control bits 1:0 select the periodic event: 0 means none, 1 means every tick, 2 means every 60th tick, 3 means every 3600th tick. Ticks are counted from the last control write, and a tick in the cycle of that write is not counted. Each event sets status bit 1.
- R10: Writing status with a 1 in bit 0 or bit 1 clears that flag, and a 0 leaves it unchanged. If a flag is set and cleared in the same cycle, it ends up set. `irq_o` is high while either flag is set.
- R11: Addresses 12 up to the top of the address space are independent read/write bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (5) | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt, OR of the status flags |

## Verification
Time fields, status flags and `irq_o` change at the same edge that captures the tick or the write. Read data appears one edge after the strobe. Each bench task therefore drives its stimulus on a falling edge and reads back over the bus, so the value is sampled on the falling edge after the capturing edge. Period checks apply exactly N−1 ticks and expect a clear flag, then apply one more tick and expect it set. This pins the event to the Nth tick after the control write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    // register addresses (time fields occupy ADR_SEC .. ADR_SEC+6 in order)
    localparam int ADR_SEC      = 0;
    localparam int NUM_TFIELDS  = 7;
    localparam int ADR_ALM      = 7;
    localparam int NUM_AFIELDS  = 3;
    localparam int ADR_CTRL     = 10;
    localparam int ADR_STAT     = 11;
    localparam int RAM_BASE     = 12;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;
        logic [2:0] dow;
        logic [4:0] dom;
        logic [3:0] mon;
        logic [6:0] year;
    } rtc_time_t;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;
    } rtc_tod_t;

    typedef enum logic [1:0] {
        PCODE_NONE = 2'd0,
        PCODE_SEC  = 2'd1,
        PCODE_MIN  = 2'd2,
        PCODE_HOUR = 2'd3
    } per_code_e;

    typedef enum logic {
        PER_IDLE = 1'b0,
        PER_RUN  = 1'b1
    } per_state_e;

    function automatic logic year_is_leap(input logic [6:0] yr);
        return (yr[1:0] == 2'b00);
    endfunction

    function automatic logic [4:0] days_in_month(input logic [3:0] mon, input logic [6:0] yr);
        logic [4:0] d;
        case (mon)
            4'd2:                       d = year_is_leap(yr) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:    d = 5'd30;
            default:                    d = 5'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_i,
    input  logic [NUM_TFIELDS-1:0] wr_sel_i,
    input  logic [7:0]             wr_data_i,
    output rtc_time_t              time_o,
    output rtc_time_t              nxt_o,
    output logic                   step_o
);

    rtc_time_t cur_q;
    rtc_time_t nxt;
    logic      any_wr;

    assign any_wr = |wr_sel_i;
    assign step_o = tick_i && !any_wr;

    // carry chain for one tick
    always_comb begin
        logic c_min, c_hr, c_day, c_mon, c_yr;
        nxt   = cur_q;
        c_min = 1'b0;
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;

        if (cur_q.sec >= 6'd59) begin
            nxt.sec = 6'd0;
            c_min   = 1'b1;
        end else begin
            nxt.sec = cur_q.sec + 6'd1;
        end

        if (c_min) begin
            if (cur_q.min >= 6'd59) begin
                nxt.min = 6'd0;
                c_hr    = 1'b1;
            end else begin
                nxt.min = cur_q.min + 6'd1;
            end
        end

        if (c_hr) begin
            if (cur_q.hour >= 5'd23) begin
                nxt.hour = 5'd0;
                c_day    = 1'b1;
            end else begin
                nxt.hour = cur_q.hour + 5'd1;
            end
        end

        if (c_day) begin
            if (cur_q.dow >= 3'd7 || cur_q.dow == 3'd0) nxt.dow = 3'd1;
            else                                        nxt.dow = cur_q.dow + 3'd1;
            if (cur_q.dom >= days_in_month(cur_q.mon, cur_q.year)) begin
                nxt.dom = 5'd1;
                c_mon   = 1'b1;
            end else begin
                nxt.dom = cur_q.dom + 5'd1;
            end
        end

        if (c_mon) begin
            if (cur_q.mon >= 4'd12) begin
                nxt.mon = 4'd1;
                c_yr    = 1'b1;
            end else begin
                nxt.mon = cur_q.mon + 4'd1;
            end
        end

        if (c_yr) begin
            if (cur_q.year >= 7'd99) nxt.year = 7'd0;
            else                     nxt.year = cur_q.year + 7'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{sec: 6'd0, min: 6'd0, hour: 5'd0, dow: 3'd1,
                       dom: 5'd1, mon: 4'd1, year: 7'd0};
        end else if (any_wr) begin
            if (wr_sel_i[0]) cur_q.sec  <= wr_data_i[5:0];
            if (wr_sel_i[1]) cur_q.min  <= wr_data_i[5:0];
            if (wr_sel_i[2]) cur_q.hour <= wr_data_i[4:0];
            if (wr_sel_i[3]) cur_q.dow  <= wr_data_i[2:0];
            if (wr_sel_i[4]) cur_q.dom  <= wr_data_i[4:0];
            if (wr_sel_i[5]) cur_q.mon  <= wr_data_i[3:0];
            if (wr_sel_i[6]) cur_q.year <= wr_data_i[6:0];
        end else if (tick_i) begin
            cur_q <= nxt;
        end
    end

    assign time_o = cur_q;
    assign nxt_o  = nxt;

    // R3
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> (cur_q.sec < 6'd60));

    // R7
    sec_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel_i[0] |=> (cur_q.sec == $past(wr_data_i[5:0])));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !any_wr) |=> $stable(cur_q));

    // R5
    dom_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && cur_q.dom != 5'd0) |=> (cur_q.dom != 5'd0));

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_AFIELDS-1:0] wr_sel_i,
    input  logic [7:0]             wr_data_i,
    input  logic                   step_i,
    input  rtc_time_t              nxt_i,
    input  logic                   en_i,
    input  logic                   clr_i,
    output rtc_tod_t               alm_o,
    output logic                   flag_o
);

    rtc_tod_t alm_q;
    logic     flag_q;
    logic     hit;

    assign hit = step_i && en_i &&
                 (nxt_i.sec  == alm_q.sec)  &&
                 (nxt_i.min  == alm_q.min)  &&
                 (nxt_i.hour == alm_q.hour);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_sel_i[0]) alm_q.sec  <= wr_data_i[5:0];
            if (wr_sel_i[1]) alm_q.min  <= wr_data_i[5:0];
            if (wr_sel_i[2]) alm_q.hour <= wr_data_i[4:0];
            if (hit)         flag_q <= 1'b1;
            else if (clr_i)  flag_q <= 1'b0;
        end
    end

    assign alm_o  = alm_q;
    assign flag_o = flag_q;

    // R8
    alarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(step_i && en_i));

    // R10
    alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !step_i) |=> !flag_q);

endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_MIN  = 60,
    parameter int TICKS_PER_HOUR = 3600
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      restart_i,
    input  logic [1:0] code_i,
    input  logic      clr_i,
    output per_code_e code_o,
    output logic      flag_o
);

    localparam int CNT_W = $clog2(TICKS_PER_HOUR + 1);
    localparam logic [CNT_W-1:0] LAST_SEC  = '0;
    localparam logic [CNT_W-1:0] LAST_MIN  = CNT_W'(TICKS_PER_MIN - 1);
    localparam logic [CNT_W-1:0] LAST_HOUR = CNT_W'(TICKS_PER_HOUR - 1);

    per_state_e       state_q, state_d;
    per_code_e        code_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] last_cnt;
    logic             fire;
    logic             flag_q;

    always_comb begin
        unique case (code_q)
            PCODE_SEC:  last_cnt = LAST_SEC;
            PCODE_MIN:  last_cnt = LAST_MIN;
            PCODE_HOUR: last_cnt = LAST_HOUR;
            default:    last_cnt = LAST_SEC;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PER_IDLE;
            code_q  <= PCODE_NONE;
            cnt_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (restart_i) code_q <= per_code_e'(code_i);
            if (fire)       flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        unique case (state_q)
            PER_IDLE: begin
                cnt_d = '0;
            end
            PER_RUN: begin
                if (tick_i) begin
                    if (cnt_q >= last_cnt) begin
                        cnt_d = '0;
                        fire  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = PER_IDLE;
        endcase
        if (restart_i) begin
            state_d = (code_i == 2'd0) ? PER_IDLE : PER_RUN;
            cnt_d   = '0;
            fire    = 1'b0;
        end
    end

    assign code_o = code_q;
    assign flag_o = flag_q;

    // R9
    per_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick_i && state_q == PER_RUN));

    // R9
    per_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PER_IDLE) |=> !$rose(flag_q));

    // R9
    per_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_HOUR);

    // R10
    per_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !tick_i) |=> !flag_q);

endmodule

// File: rtl/rtc_regblock.sv
module rtc_regblock
    import rtc_pkg::*;
#(
    parameter int ADDR_W         = 5,
    parameter int TICKS_PER_MIN  = 60,
    parameter int TICKS_PER_HOUR = 3600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic              irq_o
);

    localparam int RAM_DEPTH = (1 << ADDR_W) - RAM_BASE;

    logic                   wr, rd;
    logic [NUM_TFIELDS-1:0] tw_sel;
    logic [NUM_AFIELDS-1:0] aw_sel;
    logic                   ctrl_wr, stat_wr;
    logic                   alm_en_q;
    rtc_time_t              cal_time, cal_nxt;
    logic                   cal_step;
    rtc_tod_t               alm_regs;
    logic                   alm_flag, per_flag;
    per_code_e              per_code;
    logic [7:0]             ram_q [RAM_DEPTH];
    logic [7:0]             rd_d;
    logic [7:0]             rdata_q;

    assign wr      = bus_sel_i && bus_we_i;
    assign rd      = bus_sel_i && !bus_we_i;
    assign ctrl_wr = wr && (bus_addr_i == ADDR_W'(ADR_CTRL));
    assign stat_wr = wr && (bus_addr_i == ADDR_W'(ADR_STAT));

    for (genvar g = 0; g < NUM_TFIELDS; g++) begin : g_tsel
        assign tw_sel[g] = wr && (bus_addr_i == ADDR_W'(ADR_SEC + g));
    end
    for (genvar g = 0; g < NUM_AFIELDS; g++) begin : g_asel
        assign aw_sel[g] = wr && (bus_addr_i == ADDR_W'(ADR_ALM + g));
    end

    rtc_calendar u_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .wr_sel_i  (tw_sel),
        .wr_data_i (bus_wdata_i),
        .time_o    (cal_time),
        .nxt_o     (cal_nxt),
        .step_o    (cal_step)
    );

    rtc_alarm u_alm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel_i  (aw_sel),
        .wr_data_i (bus_wdata_i),
        .step_i    (cal_step),
        .nxt_i     (cal_nxt),
        .en_i      (alm_en_q),
        .clr_i     (stat_wr && bus_wdata_i[0]),
        .alm_o     (alm_regs),
        .flag_o    (alm_flag)
    );

    rtc_periodic #(
        .TICKS_PER_MIN  (TICKS_PER_MIN),
        .TICKS_PER_HOUR (TICKS_PER_HOUR)
    ) u_per (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .restart_i (ctrl_wr),
        .code_i    (bus_wdata_i[1:0]),
        .clr_i     (stat_wr && bus_wdata_i[1]),
        .code_o    (per_code),
        .flag_o    (per_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alm_en_q <= 1'b0;
        else if (ctrl_wr) alm_en_q <= bus_wdata_i[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RAM_DEPTH; i++) ram_q[i] <= '0;
        end else if (wr) begin
            for (int i = 0; i < RAM_DEPTH; i++)
                if (bus_addr_i == ADDR_W'(RAM_BASE + i)) ram_q[i] <= bus_wdata_i;
        end
    end

    always_comb begin
        rd_d = '0;
        case (bus_addr_i)
            ADDR_W'(ADR_SEC + 0): rd_d = {2'b0, cal_time.sec};
            ADDR_W'(ADR_SEC + 1): rd_d = {2'b0, cal_time.min};
            ADDR_W'(ADR_SEC + 2): rd_d = {3'b0, cal_time.hour};
            ADDR_W'(ADR_SEC + 3): rd_d = {5'b0, cal_time.dow};
            ADDR_W'(ADR_SEC + 4): rd_d = {3'b0, cal_time.dom};
            ADDR_W'(ADR_SEC + 5): rd_d = {4'b0, cal_time.mon};
            ADDR_W'(ADR_SEC + 6): rd_d = {1'b0, cal_time.year};
            ADDR_W'(ADR_ALM + 0): rd_d = {2'b0, alm_regs.sec};
            ADDR_W'(ADR_ALM + 1): rd_d = {2'b0, alm_regs.min};
            ADDR_W'(ADR_ALM + 2): rd_d = {3'b0, alm_regs.hour};
            ADDR_W'(ADR_CTRL):    rd_d = {5'b0, alm_en_q, per_code};
            ADDR_W'(ADR_STAT):    rd_d = {6'b0, per_flag, alm_flag};
            default: begin
                for (int i = 0; i < RAM_DEPTH; i++)
                    if (bus_addr_i == ADDR_W'(RAM_BASE + i)) rd_d = ram_q[i];
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else if (rd) rdata_q <= rd_d;
    end

    assign bus_rdata_o = rdata_q;
    assign irq_o       = alm_flag | per_flag;

    // R2
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr_i == ADDR_W'(ADR_SEC)) |=> (bus_rdata_o == {2'b0, $past(cal_time.sec)}));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata_o));

    // R11
    ram_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr_i == ADDR_W'(RAM_BASE)) |=> (ram_q[0] == $past(bus_wdata_i)));

endmodule

// File: tb/rtc_regblock_tb.sv
module rtc_regblock_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b0;
    logic          bus_sel_i = 1'b0;
    logic          bus_we_i = 1'b0;
    logic [AW-1:0] bus_addr_i = '0;
    logic [7:0]    bus_wdata_i = '0;
    logic [7:0]    bus_rdata_o;
    logic          irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_regblock #(.ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .bus_sel_i   (bus_sel_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_we_i = 1'b1;
        bus_addr_i = AW'(a); bus_wdata_i = 8'(d);
        @(negedge clk);
        bus_sel_i = 1'b0; bus_we_i = 1'b0;
    endtask

    task automatic wr_tick(input int a, input int d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_we_i = 1'b1;
        bus_addr_i = AW'(a); bus_wdata_i = 8'(d); tick_i = 1'b1;
        @(negedge clk);
        bus_sel_i = 1'b0; bus_we_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = AW'(a);
        @(negedge clk);
        bus_sel_i = 1'b0;
        d = int'(bus_rdata_o);
    endtask

    task automatic expect_reg(input string req, input int a, input int exp);
        int v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic set_time(input int yr, input int mo, input int dm, input int dw,
                            input int hr, input int mi, input int se);
        wr(0, se); wr(1, mi); wr(2, hr); wr(3, dw); wr(4, dm); wr(5, mo); wr(6, yr);
    endtask

    task automatic t_reset();
        expect_reg("R1 sec", 0, 0);
        expect_reg("R1 min", 1, 0);
        expect_reg("R1 hour", 2, 0);
        expect_reg("R1 dow", 3, 1);
        expect_reg("R1 dom", 4, 1);
        expect_reg("R1 mon", 5, 1);
        expect_reg("R1 year", 6, 0);
        expect_reg("R1 alarm hour", 9, 0);
        expect_reg("R1 ctrl", 10, 0);
        expect_reg("R1 status", 11, 0);
        check("R1 irq", int'(irq_o), 0);
    endtask

    task automatic t_regmap();
        wr(0, 8'hFF); expect_reg("R2 sec mask", 0, 8'h3F);
        wr(2, 8'hFF); expect_reg("R2 hour mask", 2, 8'h1F);
        wr(3, 8'hFF); expect_reg("R2 dow mask", 3, 8'h07);
        wr(7, 8'd45); expect_reg("R2 alarm sec", 7, 45);
        wr(8, 8'd17); expect_reg("R2 alarm min", 8, 17);
    endtask

    task automatic t_rollover();
        set_time(23, 6, 15, 3, 12, 34, 56);
        ticks(1);
        expect_reg("R3 sec step", 0, 57);
        expect_reg("R3 min kept", 1, 34);
        set_time(23, 6, 15, 3, 10, 59, 59);
        ticks(1);
        expect_reg("R3 min wrap sec", 0, 0);
        expect_reg("R3 min wrap min", 1, 0);
        expect_reg("R3 min wrap hour", 2, 11);
        set_time(23, 6, 15, 3, 23, 59, 58);
        ticks(2);
        expect_reg("R3 hour wrap", 2, 0);
        expect_reg("R3 min zero", 1, 0);
        expect_reg("R4 dow step", 3, 4);
        expect_reg("R5 dom step", 4, 16);
    endtask

    task automatic t_dow_wrap();
        set_time(23, 6, 10, 7, 23, 59, 59);
        ticks(1);
        expect_reg("R4 dow 7->1", 3, 1);
    endtask

    task automatic t_months();
        set_time(23, 4, 30, 1, 23, 59, 59);
        ticks(1);
        expect_reg("R5 apr end dom", 4, 1);
        expect_reg("R5 apr end mon", 5, 5);
        set_time(23, 5, 30, 1, 23, 59, 59);
        ticks(1);
        expect_reg("R5 may 31", 4, 31);
        set_time(23, 2, 28, 1, 23, 59, 59);
        ticks(1);
        expect_reg("R5 feb28 dom", 4, 1);
        expect_reg("R5 feb28 mon", 5, 3);
        set_time(99, 12, 31, 1, 23, 59, 59);
        ticks(1);
        expect_reg("R5 new year mon", 5, 1);
        expect_reg("R5 year wrap", 6, 0);
    endtask

    task automatic t_leap();
        set_time(24, 2, 28, 1, 23, 59, 59);
        ticks(1);
        expect_reg("R6 leap feb29", 4, 29);
        expect_reg("R6 leap feb mon", 5, 2);
        set_time(24, 2, 29, 1, 23, 59, 59);
        ticks(1);
        expect_reg("R6 leap mar1", 5, 3);
        set_time(0, 2, 28, 1, 23, 59, 59);
        ticks(1);
        expect_reg("R6 year 0 leap", 4, 29);
    endtask

    task automatic t_write_wins();
        set_time(23, 6, 15, 3, 8, 30, 5);
        wr_tick(0, 10);
        expect_reg("R7 sec write wins", 0, 10);
        wr(0, 20);
        wr_tick(1, 7);
        expect_reg("R7 sec not advanced", 0, 20);
        expect_reg("R7 min written", 1, 7);
    endtask

    task automatic t_alarm();
        wr(11, 3);
        wr(7, 3); wr(8, 2); wr(9, 1);
        wr(10, 0);
        set_time(23, 6, 15, 3, 1, 2, 2);
        ticks(1);
        expect_reg("R8 disabled no flag", 11, 0);
        wr(10, 4);
        expect_reg("R8 ctrl en", 10, 4);
        set_time(23, 6, 15, 3, 1, 2, 2);
        expect_reg("R8 before match", 11, 0);
        ticks(1);
        expect_reg("R8 alarm flag", 11, 1);
        check("R10 irq on alarm", int'(irq_o), 1);
        wr(11, 0);
        expect_reg("R10 write 0 keeps", 11, 1);
        wr(11, 1);
        expect_reg("R10 clear alarm", 11, 0);
        check("R10 irq low", int'(irq_o), 0);
    endtask

    task automatic t_periodic();
        wr(10, 1);
        ticks(1);
        expect_reg("R9 every tick", 11, 2);
        wr(11, 2);
        wr(10, 2);
        ticks(59);
        expect_reg("R9 60 not yet", 11, 0);
        ticks(1);
        expect_reg("R9 60th tick", 11, 2);
        wr(11, 2);
        wr(10, 3);
        ticks(3599);
        expect_reg("R9 3600 not yet", 11, 0);
        ticks(1);
        expect_reg("R9 3600th tick", 11, 2);
        wr(11, 2);
        wr(10, 0);
        ticks(5);
        expect_reg("R9 code 0 quiet", 11, 0);
    endtask

    task automatic t_set_wins();
        wr(10, 1);
        wr(11, 3);
        wr_tick(11, 2);
        expect_reg("R10 set beats clear", 11, 2);
        wr(10, 0);
        wr(11, 3);
    endtask

    task automatic t_ram();
        wr(12, 8'hA5);
        wr(31, 8'h5A);
        wr(20, 8'h3C);
        expect_reg("R11 ram 12", 12, 8'hA5);
        expect_reg("R11 ram 31", 31, 8'h5A);
        expect_reg("R11 ram 20", 20, 8'h3C);
        expect_reg("R11 ram 13 untouched", 13, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_rollover();
        t_dow_wrap();
        t_months();
        t_leap();
        t_write_wins();
        t_alarm();
        t_periodic();
        t_set_wins();
        t_ram();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule